// File: doc/BRIEF.md
# On-Chip Debug Mode Controller

This block sits beside a processor core and lets an external debugger steer execution. The debugger writes 32-bit command words into a single command port. The block decodes five command classes from each word. It keeps the core in one of three modes: free running, halted, or a supervised run that halts by itself. A halted core gets a pipeline stall. Peripherals are not touched, and the system timer is frozen only when a configuration input asks for it.

In the supervised run, the block counts retired instructions against a programmable limit. It also compares the program counter against a set of enabled breakpoint addresses. Either event drops the core back into the halted mode. The block records which event caused the stop. The mode used after reset comes from two strap pins, so a part can boot straight into a halt. Commands can also pulse debug exception requests, hand a resource-access request to the core, or start a self-test engine. A resource access is refused while the core runs freely if it targets a resource the core may be using.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mode follows boot_mode_i until a command or stop changes it. Mode codes are 0 = normal run, 1 = debug wait, 2 = debug run, and a pin value of 3 is taken as normal run.
- R2: The command class sits in bits [31:29] of the command word: 0 SET, 1 RUN, 2 exception, 3 resource access, 4 self-test. Classes 5, 6 and 7 set err_o and have no other effect.
- R3: A RUN command selects the mode given in bits [1:0] from the next cycle on. Code 3 sets err_o and leaves the mode unchanged. A RUN command has priority over a stop event in the same cycle.
- R4: err_o is sticky. Only a SET with select 7 clears it, and later valid commands do not clear it.
- R5: stall_o is high exactly in debug wait. timer_freeze_o is stall_o gated by cfg_timer_freeze_i.
- R6: In debug run, every retire_i pulse is counted. With a nonzero limit L, the L-th retire moves the mode to debug wait in the next cycle and sets stop_cause_o bit 0. With a limit of 0, no count stop happens.
- R7: Two breakpoint comparators each have an enable bit. In debug run, pc_i equal to an enabled breakpoint address moves the mode to debug wait and sets stop_cause_o bit 1. If a count stop and a breakpoint fall in the same cycle, both bits are set. Entering debug run clears stop_cause_o.
- R8: An exception command pulses dbg_exc_o with bits [3:0] of the word for exactly one cycle, one cycle after the write.
- R9: A resource command carries an index in bits [7:0]. In normal run, an index of 4 or more is refused: err_o is set and no request is made. Any other case pulses res_req_o for one cycle with res_idx_o equal to the index.
- R10: A self-test command pulses bist_start_o for exactly one cycle, one cycle after the write.
- R11: SET uses select bits [28:26]. Select 0 loads the step limit from bits [15:0]. Select 1 loads the breakpoint enables from bits [1:0]. Selects 2 and 3 load breakpoint 0 and breakpoint 1 addresses from bits [15:0]. Select 7 clears the error. Selects 4 to 6 set err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_mode_i | input | 2 | Strap pins choosing the mode after reset |
| cfg_timer_freeze_i | input | 1 | Freeze the timer while halted |
| cmd_valid_i | input | 1 | Command word is written this cycle |
| cmd_word_i | input | 32 | Command word |
| retire_i | input | 1 | One instruction retired this cycle |
| pc_i | input | 16 | Program counter compared to breakpoints |
| mode_o | output | 2 | Current mode |
| stall_o | output | 1 | Halt the pipeline |
| timer_freeze_o | output | 1 | Stop the system timer |
| dbg_exc_o | output | 4 | Debug exception request pulses |
| res_req_o | output | 1 | Resource access request pulse |
| res_idx_o | output | 8 | Resource index of the request |
| bist_start_o | output | 1 | Self-test start pulse |
| err_o | output | 1 | Sticky command error |
| stop_cause_o | output | 2 | Bit 0 count stop, bit 1 breakpoint stop |

## Verification
Three events can land on the same clock edge: the instruction-count limit expiring, a breakpoint match, and a debugger RUN command. The bench drives the final counted retire together with a program counter equal to an enabled breakpoint, and expects debug wait with both cause bits set. It also sends a RUN-to-normal command on the same edge as a limit expiry, and expects the command to decide the mode. In every sweep, the expected mode and cause are computed from the limit and the retire count the bench has issued.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STEP = 2'd2
  } dbg_mode_e;

  localparam logic [2:0] CMD_SET  = 3'd0;
  localparam logic [2:0] CMD_RUN  = 3'd1;
  localparam logic [2:0] CMD_EXC  = 3'd2;
  localparam logic [2:0] CMD_RES  = 3'd3;
  localparam logic [2:0] CMD_BIST = 3'd4;

  localparam logic [2:0] SEL_LIMIT = 3'd0;
  localparam logic [2:0] SEL_BPEN  = 3'd1;
  localparam logic [2:0] SEL_BP0   = 3'd2;
  localparam logic [2:0] SEL_CLR   = 3'd7;

  function automatic dbg_mode_e map_mode(logic [1:0] code);
    case (code)
      2'd1:    map_mode = MODE_WAIT;
      2'd2:    map_mode = MODE_STEP;
      default: map_mode = MODE_RUN;
    endcase
  endfunction
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_mode_pkg::*;
#(
  parameter int NBP   = 2,
  parameter int NEXC  = 4,
  parameter int NSAFE = 4,
  parameter int IDXW  = 8
) (
  input  logic             valid_i,
  input  logic [31:0]      word_i,
  input  dbg_mode_e        mode_i,
  output logic             wr_limit_o,
  output logic             wr_bpen_o,
  output logic [NBP-1:0]   wr_bp_o,
  output logic             clr_err_o,
  output logic             run_req_o,
  output dbg_mode_e        run_mode_o,
  output logic [NEXC-1:0]  exc_o,
  output logic             res_req_o,
  output logic [IDXW-1:0]  res_idx_o,
  output logic             bist_o,
  output logic             err_o
);
  logic [2:0] typ, sel;
  logic       is_set, sel_bp, sel_ok;

  assign typ = word_i[31:29];
  assign sel = word_i[28:26];
  assign is_set = valid_i && (typ == CMD_SET);

  for (genvar k = 0; k < NBP; k++) begin : g_bpsel
    assign wr_bp_o[k] = is_set && (sel == 3'(SEL_BP0 + 3'(k)));
  end

  assign sel_bp = |wr_bp_o;
  assign sel_ok = (sel == SEL_LIMIT) || (sel == SEL_BPEN) || (sel == SEL_CLR) || sel_bp;

  assign wr_limit_o = is_set && (sel == SEL_LIMIT);
  assign wr_bpen_o  = is_set && (sel == SEL_BPEN);
  assign clr_err_o  = is_set && (sel == SEL_CLR);
  assign res_idx_o  = word_i[IDXW-1:0];
  assign run_mode_o = map_mode(word_i[1:0]);

  always_comb begin
    run_req_o = 1'b0;
    exc_o     = '0;
    res_req_o = 1'b0;
    bist_o    = 1'b0;
    err_o     = 1'b0;
    if (valid_i) begin
      case (typ)
        CMD_SET:  err_o = !sel_ok;
        CMD_RUN: begin
          if (word_i[1:0] == 2'd3) err_o = 1'b1;
          else                     run_req_o = 1'b1;
        end
        CMD_EXC:  exc_o = word_i[NEXC-1:0];
        CMD_RES: begin
          // free-running core owns resources at or above NSAFE
          if (mode_i == MODE_RUN && 32'(res_idx_o) >= NSAFE) err_o = 1'b1;
          else                                             res_req_o = 1'b1;
        end
        CMD_BIST: bist_o = 1'b1;
        default:  err_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dbg_step_unit.sv
module dbg_step_unit #(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int NBP = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_step_i,
  input  logic           retire_i,
  input  logic [AW-1:0]  pc_i,
  input  logic           wr_limit_i,
  input  logic           wr_bpen_i,
  input  logic [NBP-1:0] wr_bp_i,
  input  logic [31:0]    wdata_i,
  input  logic           restart_i,
  output logic           cnt_stop_o,
  output logic           bp_hit_o,
  output logic [1:0]     cause_o
);
  logic [CW-1:0]  limit_q, cnt_q;
  logic [NBP-1:0] bpen_q, match;
  logic [AW-1:0]  bp_q [NBP];

  for (genvar k = 0; k < NBP; k++) begin : g_bp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         bp_q[k] <= '0;
      else if (wr_bp_i[k]) bp_q[k] <= wdata_i[AW-1:0];
    end
    assign match[k] = bpen_q[k] && (pc_i == bp_q[k]);
  end

  assign bp_hit_o   = in_step_i && (|match);
  assign cnt_stop_o = in_step_i && retire_i && (limit_q != '0) &&
                      ((cnt_q + CW'(1)) == limit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      bpen_q  <= '0;
    end else begin
      if (wr_limit_i) limit_q <= wdata_i[CW-1:0];
      if (wr_bpen_i)  bpen_q  <= wdata_i[NBP-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cause_o <= '0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      cause_o <= '0;
    end else begin
      if (in_step_i && retire_i && cnt_q != '1) cnt_q <= cnt_q + CW'(1);
      if (cnt_stop_o) cause_o[0] <= 1'b1;
      if (bp_hit_o)   cause_o[1] <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] boot_mode_i,
  input  logic      run_req_i,
  input  dbg_mode_e run_mode_i,
  input  logic      stop_i,
  output dbg_mode_e mode_o
);
  dbg_mode_e mode_q, mode_d;
  logic      booted_q;

  // strap pins rule until the first edge after reset
  assign mode_o = booted_q ? mode_q : map_mode(boot_mode_i);

  always_comb begin
    mode_d = mode_o;
    if (run_req_i)                          mode_d = run_mode_i;
    else if (mode_o == MODE_STEP && stop_i) mode_d = MODE_WAIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RUN;
      booted_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      booted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int NBP   = 2,
  parameter int NEXC  = 4,
  parameter int NSAFE = 4,
  parameter int IDXW  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      boot_mode_i,
  input  logic            cfg_timer_freeze_i,
  input  logic            cmd_valid_i,
  input  logic [31:0]     cmd_word_i,
  input  logic            retire_i,
  input  logic [AW-1:0]   pc_i,
  output logic [1:0]      mode_o,
  output logic            stall_o,
  output logic            timer_freeze_o,
  output logic [NEXC-1:0] dbg_exc_o,
  output logic            res_req_o,
  output logic [IDXW-1:0] res_idx_o,
  output logic            bist_start_o,
  output logic            err_o,
  output logic [1:0]      stop_cause_o
);
  dbg_mode_e       mode;
  dbg_mode_e       run_mode;
  logic            wr_limit, wr_bpen, clr_err, run_req, res_req, bist_req, cmd_err;
  logic [NBP-1:0]  wr_bp;
  logic [NEXC-1:0] exc_req;
  logic [IDXW-1:0] res_idx;
  logic            cnt_stop, bp_hit, restart;

  dbg_cmd_decode #(.NBP(NBP), .NEXC(NEXC), .NSAFE(NSAFE), .IDXW(IDXW)) u_dec (
    .valid_i    (cmd_valid_i),
    .word_i     (cmd_word_i),
    .mode_i     (mode),
    .wr_limit_o (wr_limit),
    .wr_bpen_o  (wr_bpen),
    .wr_bp_o    (wr_bp),
    .clr_err_o  (clr_err),
    .run_req_o  (run_req),
    .run_mode_o (run_mode),
    .exc_o      (exc_req),
    .res_req_o  (res_req),
    .res_idx_o  (res_idx),
    .bist_o     (bist_req),
    .err_o      (cmd_err)
  );

  assign restart = run_req && (run_mode == MODE_STEP);

  dbg_step_unit #(.AW(AW), .CW(CW), .NBP(NBP)) u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_step_i  (mode == MODE_STEP),
    .retire_i   (retire_i),
    .pc_i       (pc_i),
    .wr_limit_i (wr_limit),
    .wr_bpen_i  (wr_bpen),
    .wr_bp_i    (wr_bp),
    .wdata_i    (cmd_word_i),
    .restart_i  (restart),
    .cnt_stop_o (cnt_stop),
    .bp_hit_o   (bp_hit),
    .cause_o    (stop_cause_o)
  );

  dbg_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_mode_i (boot_mode_i),
    .run_req_i   (run_req),
    .run_mode_i  (run_mode),
    .stop_i      (cnt_stop | bp_hit),
    .mode_o      (mode)
  );

  assign mode_o         = mode;
  assign stall_o        = (mode == MODE_WAIT);
  assign timer_freeze_o = stall_o & cfg_timer_freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_exc_o    <= '0;
      res_req_o    <= 1'b0;
      res_idx_o    <= '0;
      bist_start_o <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      dbg_exc_o    <= exc_req;
      res_req_o    <= res_req;
      bist_start_o <= bist_req;
      if (res_req) res_idx_o <= res_idx;
      if (clr_err)      err_o <= 1'b0;
      else if (cmd_err) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk #(
  parameter int NEXC  = 4,
  parameter int NSAFE = 4,
  parameter int IDXW  = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic [31:0]     cmd_word_i,
  input logic [1:0]      mode_o,
  input logic            stall_o,
  input logic            timer_freeze_o,
  input logic [NEXC-1:0] dbg_exc_o,
  input logic            res_req_o,
  input logic [IDXW-1:0] res_idx_o,
  input logic            err_o,
  input logic            cnt_stop,
  input logic            bp_hit
);
  // R1
  a_r1_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  // R5
  a_r5_freeze_needs_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_freeze_o |-> stall_o);

  // R6, R7
  a_r6_stop_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && !cmd_valid_i && (cnt_stop || bp_hit)) |=> mode_o == 2'd1);

  // R4
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(cmd_valid_i && cmd_word_i[31:26] == 6'b000111)) |=> err_o);

  // R8
  a_r8_exc_from_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[31:29] == 3'd2) |=> dbg_exc_o == $past(cmd_word_i[NEXC-1:0]));

  // R9
  a_r9_safe_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[31:29] == 3'd3 && mode_o == 2'd0 &&
     32'(cmd_word_i[IDXW-1:0]) >= NSAFE) |=> !res_req_o);

  // R9
  a_r9_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_req_o && !(cmd_valid_i && cmd_word_i[31:29] == 3'd3)) |=> !res_req_o);

  // R9
  a_r9_idx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_req_o |=> (res_req_o || $stable(res_idx_o)));
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk #(.NEXC(NEXC), .NSAFE(NSAFE), .IDXW(IDXW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_word_i     (cmd_word_i),
  .mode_o         (mode_o),
  .stall_o        (stall_o),
  .timer_freeze_o (timer_freeze_o),
  .dbg_exc_o      (dbg_exc_o),
  .res_req_o      (res_req_o),
  .res_idx_o      (res_idx_o),
  .err_o          (err_o),
  .cnt_stop       (cnt_stop),
  .bp_hit         (bp_hit)
);

// File: tb/dbg_mode_ctrl_tb.sv
module dbg_mode_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot = 2'd0;
  logic        cfg_frz = 1'b0;
  logic        cmd_v = 1'b0;
  logic [31:0] cmd_w = '0;
  logic        ret = 1'b0;
  logic [15:0] pc = 16'h0050;
  logic [1:0]  mode;
  logic        stall, frz, res_req, bist, err;
  logic [3:0]  exc;
  logic [7:0]  res_idx;
  logic [1:0]  cause;
  int n_vec = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_mode_i(boot), .cfg_timer_freeze_i(cfg_frz),
    .cmd_valid_i(cmd_v), .cmd_word_i(cmd_w), .retire_i(ret), .pc_i(pc),
    .mode_o(mode), .stall_o(stall), .timer_freeze_o(frz), .dbg_exc_o(exc),
    .res_req_o(res_req), .res_idx_o(res_idx), .bist_start_o(bist),
    .err_o(err), .stop_cause_o(cause)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(logic [31:0] w);
    cmd_v = 1'b1; cmd_w = w;
    tick();
    cmd_v = 1'b0; cmd_w = '0;
  endtask

  function automatic logic [31:0] mk(int typ, int sel, int data);
    return (32'(typ) << 29) | (32'(sel) << 26) | 32'(data);
  endfunction

  task automatic do_reset(logic [1:0] b);
    boot = b; rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic clr_err();
    send(mk(0, 7, 0));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    // R1 boot straps
    for (int b = 0; b < 4; b++) begin
      do_reset(2'(b));
      chk("R1 mode at reset", 32'(mode), (b == 3) ? 0 : b);
      chk("R1 err at reset", 32'(err), 0);
      chk("R8 exc at reset", 32'(exc), 0);
      tick(); tick();
      chk("R1 mode held", 32'(mode), (b == 3) ? 0 : b);
      chk("R5 stall vs boot", 32'(stall), (b == 1) ? 1 : 0);
    end
    do_reset(2'd0);
    tick();

    // R5 stall and timer freeze
    send(mk(1, 0, 1));
    for (int c = 0; c < 2; c++) begin
      cfg_frz = 1'(c); #1;
      chk("R5 stall in wait", 32'(stall), 1);
      chk("R5 freeze", 32'(frz), 32'(c));
    end
    send(mk(1, 0, 0));
    chk("R3 back to normal", 32'(mode), 0);
    chk("R5 no stall", 32'(stall), 0);
    chk("R5 no freeze", 32'(frz), 0);
    cfg_frz = 1'b0;

    // R3 illegal target, R4 sticky error
    send(mk(1, 0, 3));
    chk("R3 code3 mode", 32'(mode), 0);
    chk("R3 code3 err", 32'(err), 1);
    send(mk(2, 0, 0));
    chk("R4 err sticky", 32'(err), 1);
    tick();
    chk("R4 err sticky idle", 32'(err), 1);
    clr_err();
    chk("R4 err cleared", 32'(err), 0);

    // R2 undefined classes
    send(mk(1, 0, 1));
    for (int t = 5; t < 8; t++) begin
      send(mk(t, 0, 32'h3F));
      chk("R2 undef err", 32'(err), 1);
      chk("R2 undef mode", 32'(mode), 1);
      chk("R2 undef exc", 32'(exc), 0);
      chk("R2 undef res", 32'(res_req), 0);
      chk("R2 undef bist", 32'(bist), 0);
      clr_err();
    end
    send(mk(1, 0, 0));

    // R8 exception pulses
    for (int p = 0; p < 16; p++) begin
      send(mk(2, 0, p | 32'h30));
      chk("R8 exc pulse", 32'(exc), 32'(p));
      tick();
      chk("R8 exc gone", 32'(exc), 0);
    end

    // R9 resource access per mode
    for (int m = 0; m < 3; m++) begin
      send(mk(1, 0, m));
      for (int i = 0; i < 8; i++) begin
        bit ok;
        ok = (m != 0) || (i < 4);
        send(mk(3, 0, i | 32'h100));
        chk("R9 res req", 32'(res_req), 32'(ok));
        chk("R9 res err", 32'(err), 32'(!ok));
        if (ok) chk("R9 res idx", 32'(res_idx), 32'(i));
        tick();
        chk("R9 res one cycle", 32'(res_req), 0);
        if (!ok) clr_err();
      end
    end
    send(mk(1, 0, 0));

    // R10 self-test start
    send(mk(4, 0, 0));
    chk("R10 bist pulse", 32'(bist), 1);
    tick();
    chk("R10 bist gone", 32'(bist), 0);

    // R11 bad select
    for (int s = 4; s < 7; s++) begin
      send(mk(0, s, 0));
      chk("R11 bad sel err", 32'(err), 1);
      clr_err();
    end

    // R6 count stops for limits 1..5
    for (int n = 1; n <= 5; n++) begin
      send(mk(0, 0, n));
      send(mk(1, 0, 2));
      chk("R7 cause cleared", 32'(cause), 0);
      for (int k = 1; k <= n; k++) begin
        ret = 1'b1; tick(); ret = 1'b0;
        chk("R6 mode after retire", 32'(mode), (k == n) ? 1 : 2);
      end
      chk("R6 cause count", 32'(cause), 1);
      chk("R6 stall", 32'(stall), 1);
      tick();
      chk("R6 stays wait", 32'(mode), 1);
    end
    // R6 limit 0
    send(mk(0, 0, 0));
    send(mk(1, 0, 2));
    for (int k = 0; k < 10; k++) begin
      ret = 1'b1; tick();
    end
    ret = 1'b0;
    chk("R6 no limit", 32'(mode), 2);
    chk("R6 no limit cause", 32'(cause), 0);

    // R7 each comparator, other disabled
    send(mk(0, 2, 16'h0100));
    send(mk(0, 3, 16'h0200));
    for (int k = 0; k < 2; k++) begin
      send(mk(0, 1, 1 << k));
      send(mk(1, 0, 2));
      pc = (k == 0) ? 16'h0200 : 16'h0100;
      tick();
      chk("R7 disabled bp", 32'(mode), 2);
      pc = (k == 0) ? 16'h0100 : 16'h0200;
      tick();
      pc = 16'h0050;
      chk("R7 bp stop", 32'(mode), 1);
      chk("R7 bp cause", 32'(cause), 2);
    end

    // R7 count and breakpoint together
    send(mk(0, 0, 3));
    send(mk(0, 1, 1));
    send(mk(1, 0, 2));
    ret = 1'b1; tick(); tick();
    chk("R7 pre coincide", 32'(mode), 2);
    pc = 16'h0100; tick();
    ret = 1'b0; pc = 16'h0050;
    chk("R7 coincide mode", 32'(mode), 1);
    chk("R7 coincide cause", 32'(cause), 3);

    // R3 command beats stop
    send(mk(0, 1, 0));
    send(mk(0, 0, 2));
    send(mk(1, 0, 2));
    ret = 1'b1; tick();
    cmd_v = 1'b1; cmd_w = mk(1, 0, 0);
    tick();
    cmd_v = 1'b0; cmd_w = '0; ret = 1'b0;
    chk("R3 cmd wins", 32'(mode), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule